// File: doc/BRIEF.md
# Halfword-to-Longword Receive FIFO with DMA Request Alarm

This block is a receive buffer between a 16-bit disk bus interface and a system DMA engine. The bus side pushes halfwords one at a time. The DMA pulls packed 32-bit longwords, with the earlier halfword in the low half. The fill level is kept in halfwords. A DMA request is raised whenever that level is above a programmable alarm threshold and DMA emptying is enabled. Software normally sets the threshold to twice the packet size in longwords, so a request always means at least one whole packet is ready.

When a transfer ends, what is left may be smaller than a packet, and the DMA does not collect it. The host drains that residue through a separate halfword read strobe, which removes one halfword per read. A synchronous flush input empties the buffer and clears the error flags. Full and empty flags are provided, along with sticky overflow and underflow flags.

Top module: `rx_pack_fifo`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, dma_req is 0, ovf and udf are 0, and both read data outputs are 0.
- R2: Halfwords leave in the order they were written. A longword read puts the older of the two head halfwords in bits 15:0 and the newer in bits 31:16 of rd_long. rd_long updates on the clock edge that samples rd_long_en.
- R3: level counts stored halfwords: +1 for each accepted write, −2 for each successful longword read, −1 for each successful halfword read. A write and a read in the same cycle combine. empty is high exactly at level 0 and full exactly at level DEPTH.
- R4: With dma_en high, dma_req is high exactly when level is strictly greater than alarm_lvl.
- R5: With dma_en low, dma_req stays low at any fill level.
- R6: A halfword read loads the oldest halfword into rd_half on the sampling edge and removes exactly one halfword. This lets an odd residue be drained.
- R7: An under-filled read does not remove any data, loads 0 into its data output and sets the sticky udf flag. An under-filled read is a longword read at level below 2, or a halfword read at level 0.
- R8: A write at a cycle that starts with level equal to DEPTH is dropped, even if a read happens in the same cycle, and it sets the sticky ovf flag.
- R9: flush empties the FIFO, clears ovf and udf and zeroes both read outputs. It overrides any write or read presented in the same cycle.
- R10: When rd_long_en and rd_half_en are both high, only the longword read is performed. rd_half keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Synchronous buffer flush and flag clear |
| dma_en | input | 1 | Allows DMA requests |
| alarm_lvl | input | LW | Request threshold in halfwords |
| wr_en | input | 1 | Bus-side halfword write strobe |
| wr_half | input | 16 | Bus-side halfword data |
| rd_long_en | input | 1 | Longword read strobe (DMA) |
| rd_long | output | 32 | Last longword read |
| rd_half_en | input | 1 | Halfword read strobe (host residue) |
| rd_half | output | 16 | Last halfword read |
| level | output | LW | Fill level in halfwords |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level equals zero |
| dma_req | output | 1 | DMA service request |
| ovf | output | 1 | Sticky overflow flag |
| udf | output | 1 | Sticky underflow flag |

## Verification
The bench targets several corner cases:
- **Same-cycle write and read.** A design that lets the later update win would leave a level that is 1 or 2 off.
- **Threshold equal to level.** An inclusive compare would request a packet one halfword too early.
- **Write to a full buffer while a read drains it.** A design that looks at the post-read level would accept data it should drop.
- **Longword read with a single halfword left, and simultaneous read strobes.** A wrong design would pop half a word, or pop three halfwords.

It also checks that flush beats a concurrent write, and that the halfword order is kept across pointer positions that are not aligned to a longword.

// File: rtl/rxf_pkg.sv
// Package: shared types for the receive FIFO.
// Assumes: read requests are decoded into one kind per cycle.
package rxf_pkg;
    typedef enum logic [1:0] {
        POP_NONE = 2'd0,
        POP_HALF = 2'd1,
        POP_LONG = 2'd2
    } pop_kind_e;

    // Number of halfwords a read of this kind removes.
    function automatic logic [1:0] pop_size(pop_kind_e k);
        case (k)
            POP_HALF: return 2'd1;
            POP_LONG: return 2'd2;
            default:  return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/rxf_ctrl.sv
// Module: rxf_ctrl
// Keeps the halfword fill level. Decides which write and read are
// accepted this cycle, and holds the sticky overflow and underflow flags.
// Assumes: flush is synchronous and takes priority over all strobes.
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic          rd_long_en,
    input  logic          rd_half_en,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          ovf,
    output logic          udf,
    output logic          wr_ok,
    output pop_kind_e     req,
    output logic          rd_ok
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [1:0]    need;
    logic [LW-1:0] popn;
    logic [LW-1:0] level_nxt;

    // Flags decoded from the registered level.
    assign full  = (level == FULL_LVL);
    assign empty = (level == '0);

    // Pick the read kind (longword wins) and test that enough data is stored.
    always_comb begin
        if (flush)           req = POP_NONE;
        else if (rd_long_en) req = POP_LONG;
        else if (rd_half_en) req = POP_HALF;
        else                 req = POP_NONE;
        need      = pop_size(req);
        rd_ok     = (req != POP_NONE) && (level >= LW'(need));
        wr_ok     = wr_en && !flush && !full;
        popn      = rd_ok ? LW'(need) : '0;
        level_nxt = level + LW'(wr_ok) - popn;
    end

    // Level register and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
            ovf   <= 1'b0;
            udf   <= 1'b0;
        end else begin
            level <= level_nxt;
            if (wr_en && full) ovf <= 1'b1;
            if ((req != POP_NONE) && !rd_ok) udf <= 1'b1;
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);
    p_level_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> level <= $past(level) + 1'b1);
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !flush) |=> ovf);
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flush) |=> ovf);
    p_udf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (udf && !flush) |=> udf);
    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && !ovf && !udf);
endmodule

// File: rtl/rxf_store.sv
// Module: rxf_store
// Halfword storage ring with a write pointer and a read pointer. Read
// results are registered: a longword packs the head halfword low.
// Assumes: the controller only grants reads that stay within stored data,
// and grants no write at full.
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int HW = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_ok,
    input  logic [HW-1:0] wr_half,
    input  pop_kind_e     req,
    input  logic          rd_ok,
    output logic [2*HW-1:0] rd_long,
    output logic [HW-1:0]   rd_half
);
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [HW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] rd_ptr1;

    assign rd_ptr1 = rd_ptr + ONE;

    // Storage array write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_half;
    end

    // Write pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) wr_ptr <= '0;
        else if (wr_ok)      wr_ptr <= wr_ptr + ONE;
    end

    // Read pointer advance and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr  <= '0;
            rd_long <= '0;
            rd_half <= '0;
        end else begin
            case (req)
                POP_LONG: begin
                    rd_long <= rd_ok ? {mem[rd_ptr1], mem[rd_ptr]} : '0;
                    if (rd_ok) rd_ptr <= rd_ptr + TWO;
                end
                POP_HALF: begin
                    rd_half <= rd_ok ? mem[rd_ptr] : '0;
                    if (rd_ok) rd_ptr <= rd_ptr1;
                end
                default: ;
            endcase
        end
    end

    p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rd_long == '0) && (rd_half == '0));
    p_half_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req != POP_HALF && !flush) |=> $stable(rd_half));
endmodule

// File: rtl/rxf_alarm.sv
// Module: rxf_alarm
// Raises the DMA service request while the level exceeds the threshold
// and DMA emptying is allowed.
// Assumes: level and threshold share a width and count halfwords.
module rxf_alarm #(
    parameter int LW = 6
) (
    input  logic          dma_en,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] alarm_lvl,
    output logic          dma_req
);
    // Strict compare: a level equal to the threshold does not request.
    always_comb dma_req = dma_en && (level > alarm_lvl);
endmodule

// File: rtl/rx_pack_fifo.sv
// Module: rx_pack_fifo (top)
// Receive FIFO from a 16-bit disk bus to a 32-bit DMA reader, with a host
// halfword port for residue, and a programmable request alarm.
// Assumes: DEPTH is a power of two, at least 4; single clock domain.
module rx_pack_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int HW = 16,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          dma_en,
    input  logic [LW-1:0] alarm_lvl,
    input  logic          wr_en,
    input  logic [HW-1:0] wr_half,
    input  logic          rd_long_en,
    output logic [2*HW-1:0] rd_long,
    input  logic          rd_half_en,
    output logic [HW-1:0] rd_half,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          dma_req,
    output logic          ovf,
    output logic          udf
);
    logic      wr_ok;
    logic      rd_ok;
    pop_kind_e req;

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .rd_long_en(rd_long_en), .rd_half_en(rd_half_en),
        .level(level), .full(full), .empty(empty), .ovf(ovf), .udf(udf),
        .wr_ok(wr_ok), .req(req), .rd_ok(rd_ok)
    );

    rxf_store #(.DEPTH(DEPTH), .HW(HW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_ok(wr_ok),
        .wr_half(wr_half), .req(req), .rd_ok(rd_ok),
        .rd_long(rd_long), .rd_half(rd_half)
    );

    rxf_alarm #(.LW(LW)) u_alarm (
        .dma_en(dma_en), .level(level), .alarm_lvl(alarm_lvl),
        .dma_req(dma_req)
    );

    p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);
    p_req_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (level > alarm_lvl) && !empty);
endmodule

// File: tb/rx_pack_fifo_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checks at the ports.
module rx_pack_fifo_bench;
    localparam int DEPTH = 32;
    localparam int LW = 6;

    logic clk = 0, rst_n = 0, flush = 0, dma_en = 0;
    logic [LW-1:0] alarm_lvl = '0;
    logic wr_en = 0, rd_long_en = 0, rd_half_en = 0;
    logic [15:0] wr_half = '0;
    logic [31:0] rd_long;
    logic [15:0] rd_half;
    logic [LW-1:0] level;
    logic full, empty, dma_req, ovf, udf;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_pack_fifo #(.DEPTH(DEPTH)) u_rx_pack_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .dma_en(dma_en),
        .alarm_lvl(alarm_lvl), .wr_en(wr_en), .wr_half(wr_half),
        .rd_long_en(rd_long_en), .rd_long(rd_long), .rd_half_en(rd_half_en),
        .rd_half(rd_half), .level(level), .full(full), .empty(empty),
        .dma_req(dma_req), .ovf(ovf), .udf(udf)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, sample 1 ns after the rising edge.
    task automatic step(bit w, logic [15:0] d, bit rl, bit rh, bit fl);
        @(negedge clk);
        wr_en = w; wr_half = d; rd_long_en = rl; rd_half_en = rh; flush = fl;
        @(posedge clk);
        #1;
        wr_en = 0; rd_long_en = 0; rd_half_en = 0; flush = 0;
    endtask

    task automatic do_flush();
        step(0, 0, 0, 0, 1);
    endtask

    task automatic t_reset();
        check("R1 level", 32'(level), 0);
        check("R1 empty", 32'(empty), 1);
        check("R1 full", 32'(full), 0);
        check("R1 dma_req", 32'(dma_req), 0);
        check("R1 flags", {30'd0, ovf, udf}, 0);
        check("R1 rd_long", rd_long, 0);
        check("R1 rd_half", 32'(rd_half), 0);
    endtask

    task automatic t_order();
        do_flush();
        step(1, 16'h1111, 0, 0, 0);
        step(1, 16'h2222, 0, 0, 0);
        step(1, 16'h3333, 0, 0, 0);
        step(1, 16'h4444, 0, 0, 0);
        check("R3 level after 4 writes", 32'(level), 4);
        step(0, 0, 1, 0, 0);
        check("R2 first longword", rd_long, 32'h2222_1111);
        check("R3 level after long read", 32'(level), 2);
        step(0, 0, 1, 0, 0);
        check("R2 second longword", rd_long, 32'h4444_3333);
        check("R3 empty at 0", 32'(empty), 1);
    endtask

    task automatic t_concurrent();
        do_flush();
        step(1, 16'hA001, 0, 0, 0);
        step(1, 16'hA002, 0, 0, 0);
        step(1, 16'hA003, 1, 0, 0);
        check("R3 write+long read level", 32'(level), 1);
        check("R2 read during write", rd_long, 32'hA002_A001);
        step(1, 16'hA004, 0, 1, 0);
        check("R3 write+half read level", 32'(level), 1);
        check("R6 half read data", 32'(rd_half), 32'h0000_A003);
    endtask

    task automatic t_alarm();
        do_flush();
        alarm_lvl = 6'd4;
        dma_en = 1;
        for (int i = 0; i < 4; i++) step(1, 16'(i), 0, 0, 0);
        check("R4 level equal to threshold no req", 32'(dma_req), 0);
        step(1, 16'h0004, 0, 0, 0);
        #1 check("R4 level above threshold req", 32'(dma_req), 1);
        dma_en = 0;
        #1 check("R5 disabled no req", 32'(dma_req), 0);
        dma_en = 1;
        step(0, 0, 1, 0, 0);
        check("R4 req drops after packet read", 32'(dma_req), 0);
        dma_en = 0;
    endtask

    task automatic t_residue();
        do_flush();
        step(1, 16'hB00A, 0, 0, 0);
        step(1, 16'hB00B, 0, 0, 0);
        step(1, 16'hB00C, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        check("R2 residue packet", rd_long, 32'hB00B_B00A);
        step(0, 0, 1, 0, 0);
        check("R7 short long read zero", rd_long, 0);
        check("R7 short long read keeps level", 32'(level), 1);
        check("R7 udf set", 32'(udf), 1);
        step(0, 0, 0, 1, 0);
        check("R6 residue halfword", 32'(rd_half), 32'h0000_B00C);
        check("R6 residue drained", 32'(empty), 1);
        step(0, 0, 0, 1, 0);
        check("R7 empty half read zero", 32'(rd_half), 0);
        check("R7 udf sticky", 32'(udf), 1);
    endtask

    task automatic t_overflow();
        do_flush();
        check("R9 flush clears udf", 32'(udf), 0);
        step(1, 16'hC0FF, 0, 1, 0);
        step(0, 0, 0, 1, 0);
        for (int i = 0; i < DEPTH; i++) step(1, 16'h0A00 + 16'(i), 0, 0, 0);
        check("R3 full at DEPTH", 32'(full), 1);
        check("R8 no ovf yet", 32'(ovf), 0);
        step(1, 16'hDEAD, 1, 0, 0);
        check("R8 write at full dropped", 32'(level), DEPTH - 2);
        check("R8 ovf set", 32'(ovf), 1);
        check("R2 unaligned head after wrap", rd_long, 32'h0A01_0A00);
        for (int i = 0; i < DEPTH / 2 - 1; i++) step(0, 0, 1, 0, 0);
        check("R8 last data kept, dropped not stored", rd_long, 32'h0A1F_0A1E);
        check("R3 drained", 32'(empty), 1);
    endtask

    task automatic t_flush();
        step(1, 16'hE001, 0, 0, 0);
        step(1, 16'hE002, 0, 0, 1);
        check("R9 flush beats write", 32'(level), 0);
        check("R9 flags clear", {30'd0, ovf, udf}, 0);
        check("R9 rd_long cleared", rd_long, 0);
    endtask

    task automatic t_both();
        do_flush();
        step(1, 16'h0011, 0, 0, 0);
        step(1, 16'h0022, 0, 0, 0);
        step(1, 16'h0033, 0, 0, 0);
        step(1, 16'h0044, 0, 0, 0);
        step(0, 0, 1, 1, 0);
        check("R10 long read taken", rd_long, 32'h0022_0011);
        check("R10 only two removed", 32'(level), 2);
        check("R10 rd_half unchanged", 32'(rd_half), 0);
        step(0, 0, 0, 1, 0);
        check("R10 next half is third", 32'(rd_half), 32'h0000_0033);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_order();
        t_concurrent();
        t_alarm();
        t_residue();
        t_overflow();
        t_flush();
        t_both();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule